// File: doc/BRIEF.md
# Interrupt Source Event-State Table

This block keeps the per-source event state for a set of interrupt sources addressed by a 13-bit source number, a space of 8K numbers of which the first `SRC_COUNT` are implemented. Every source has a two-bit event state, a routing-level mask bit and a type flag that marks it as edge/message signalled (0) or level-sensitive (1). An incoming trigger either forwards a notification, folds into an event already in flight, or is dropped. An end-of-interrupt moves the source back toward ready and replays one notification when an event was held back. Level-sensitive sources whose line is still high at end-of-interrupt fire again at once.

Software reaches the same table through one access port. It can read a source, swap its event state atomically (the old value comes back, the new value is written in the same cycle), or write its mask and type. Notifications come out on two registered strobe channels, one for trigger-caused events and one for end-of-interrupt replays, each carrying the source number.

Within one cycle, operations on the same source apply in a fixed order: trigger first, end-of-interrupt second, software access last.

Top module: `isrc_pq_array`

## Requirements
- R1: After reset every implemented source reads state 01 (off), mask 1, type 0, and both notify strobes are low.
- R2: A trigger to a source in state 00 (ready) moves it to 10 (pending) and, when unmasked, raises `ntf_trig_vld` one cycle later with `ntf_trig_id` equal to the source number.
- R3: A trigger to a source in 10 moves it to 11 (queued); a trigger in 11 leaves it in 11; neither notifies.
- R4: A trigger to a source in 01 (off) changes nothing and raises no notify.
- R5: A set mask bit blocks both notify channels for that source while its state still moves as in R2, R3, R6 and R7.
- R6: End-of-interrupt moves 10 to 00 for a type-0 source; moves 11 to 10 and, when unmasked, raises `ntf_eoi_vld` one cycle later with `ntf_eoi_id` equal to the source; leaves 00 and 01 unchanged without notify.
- R7: For a type-1 source, end-of-interrupt with `eoi_level` high from 10 or 11 leaves it in 10 and replays a notify (when unmasked); with the level low it behaves as in R6.
- R8: Software op codes: 00 read, 01 swap, 10 configure, 11 no action. A read raises `rsp_vld` one cycle later with the source's state, mask and type and alters nothing.
- R9: A swap returns the state held before it on `rsp_pq` one cycle later and writes `sw_pq` into the source in the same cycle.
- R10: A configure writes `sw_mask` and `sw_lsi` into the source, returns no response and leaves the state unchanged.
- R11: Trigger, end-of-interrupt and software access to one source in the same cycle apply in that order; a read or swap sees the state after the trigger and end-of-interrupt.
- R12: Accesses to source numbers at or above `SRC_COUNT` change nothing, never notify, and a read of them returns state 01, mask 1, type 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_vld | input | 1 | Trigger strobe |
| trig_id | input | 13 | Source number of the trigger |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 13 | Source number of the end-of-interrupt |
| eoi_level | input | 1 | Line level of a level-sensitive source at end-of-interrupt |
| sw_vld | input | 1 | Software access strobe |
| sw_op | input | 2 | Software op code (see R8) |
| sw_id | input | 13 | Source number of the software access |
| sw_pq | input | 2 | New state for a swap |
| sw_mask | input | 1 | Mask value for a configure |
| sw_lsi | input | 1 | Type value for a configure |
| ntf_trig_vld | output | 1 | Trigger notify strobe |
| ntf_trig_id | output | 13 | Source number of the trigger notify |
| ntf_eoi_vld | output | 1 | Replay notify strobe |
| ntf_eoi_id | output | 13 | Source number of the replay notify |
| rsp_vld | output | 1 | Software read/swap response strobe |
| rsp_pq | output | 2 | Returned state |
| rsp_mask | output | 1 | Returned mask |
| rsp_lsi | output | 1 | Returned type |

## Verification
The assertions assume only that reset is held for at least one clock edge and that each strobe carries a single source number per cycle; they place no limit on which sources the three ports hit together. The stimulus therefore draws source numbers from a small window that straddles `SRC_COUNT`, so that same-cycle collisions on one source and out-of-range numbers both come up often, and it drives the level input freely, including on type-0 sources where it must have no effect.

// File: rtl/isrc_pkg.sv
// Shared encodings and state-transition rules for the interrupt source table.
// Assumes callers apply the trigger rule before the end-of-interrupt rule.
package isrc_pkg;

    typedef enum logic [1:0] {
        PQ_READY  = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_SWAP = 2'b01,
        OP_CFG  = 2'b10,
        OP_NONE = 2'b11
    } swop_e;

    // State reached when a trigger lands on a source.
    function automatic logic [1:0] pq_after_trig(input logic [1:0] pq);
        logic [1:0] nxt;
        case (pq)
            PQ_READY: nxt = PQ_PEND;
            PQ_PEND:  nxt = PQ_QUEUED;
            default:  nxt = pq;
        endcase
        return nxt;
    endfunction

    // State reached when an end-of-interrupt lands on a source.
    function automatic logic [1:0] pq_after_eoi(input logic [1:0] pq,
                                                input logic is_lvl,
                                                input logic lvl_hi);
        logic [1:0] nxt;
        case (pq)
            PQ_PEND:   nxt = (is_lvl && lvl_hi) ? PQ_PEND : PQ_READY;
            PQ_QUEUED: nxt = PQ_PEND;
            default:   nxt = pq;
        endcase
        return nxt;
    endfunction

    // True when an end-of-interrupt must send a fresh notification.
    function automatic logic eoi_replays(input logic [1:0] pq,
                                         input logic is_lvl,
                                         input logic lvl_hi);
        return (pq == PQ_QUEUED) || (pq == PQ_PEND && is_lvl && lvl_hi);
    endfunction

endpackage

// File: rtl/isrc_entry.sv
// One source of the table: event state, routing mask and type flag.
// Applies trigger, then end-of-interrupt, then software access in one cycle.
// Assumes hit inputs are already qualified by their strobes.
module isrc_entry
    import isrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_hit,
    input  logic       eoi_hit,
    input  logic       eoi_lvl,
    input  logic       sw_hit,
    input  logic [1:0] sw_op,
    input  logic [1:0] sw_pq,
    input  logic       sw_mask,
    input  logic       sw_lsi,
    output logic       trig_ntf,
    output logic       eoi_ntf,
    output logic [1:0] view_pq,
    output logic       view_mask,
    output logic       view_lsi
);

    logic [1:0] pq_q;
    logic       mask_q;
    logic       lsi_q;
    logic [1:0] pq_t;
    logic [1:0] pq_e2;
    logic [1:0] pq_d;
    logic       mask_d;
    logic       lsi_d;

    // Sequence the three same-cycle operations and derive notifications.
    always_comb begin
        pq_t     = trig_hit ? pq_after_trig(pq_q) : pq_q;
        trig_ntf = trig_hit && (pq_q == PQ_READY) && !mask_q;
        pq_e2    = eoi_hit ? pq_after_eoi(pq_t, lsi_q, eoi_lvl) : pq_t;
        eoi_ntf  = eoi_hit && eoi_replays(pq_t, lsi_q, eoi_lvl) && !mask_q;
        pq_d     = (sw_hit && sw_op == OP_SWAP) ? sw_pq : pq_e2;
        mask_d   = (sw_hit && sw_op == OP_CFG) ? sw_mask : mask_q;
        lsi_d    = (sw_hit && sw_op == OP_CFG) ? sw_lsi : lsi_q;
    end

    // Hold the per-source state; reset puts the source off and masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q   <= PQ_OFF;
            mask_q <= 1'b1;
            lsi_q  <= 1'b0;
        end else begin
            pq_q   <= pq_d;
            mask_q <= mask_d;
            lsi_q  <= lsi_d;
        end
    end

    assign view_pq   = pq_e2;
    assign view_mask = mask_q;
    assign view_lsi  = lsi_q;

    AST_OFF_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !eoi_hit && !sw_hit && pq_q == PQ_OFF) |=> (pq_q == PQ_OFF)); // R4
    AST_READY_TO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !eoi_hit && !sw_hit && pq_q == PQ_READY) |=> (pq_q == PQ_PEND)); // R2
    AST_QUEUED_EOI_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !trig_hit && !sw_hit && pq_q == PQ_QUEUED) |=> (pq_q == PQ_PEND)); // R6
    AST_SWAP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hit && sw_op == OP_SWAP) |=> (pq_q == $past(sw_pq))); // R9
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_hit && sw_op == OP_CFG) |=> $stable(mask_q)); // R10

endmodule

// File: rtl/isrc_rd_port.sv
// Software response path: picks the addressed source's view and registers it.
// Assumes SRC_COUNT >= 2; numbers outside the table read as off and masked.
module isrc_rd_port
    import isrc_pkg::*;
#(
    parameter int SRC_COUNT = 1024,
    parameter int ID_W      = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_vld,
    input  logic [1:0]                 sw_op,
    input  logic [ID_W-1:0]            sw_id,
    input  logic [SRC_COUNT-1:0][1:0]  v_pq,
    input  logic [SRC_COUNT-1:0]       v_mask,
    input  logic [SRC_COUNT-1:0]       v_lsi,
    output logic                       rsp_vld,
    output logic [1:0]                 rsp_pq,
    output logic                       rsp_mask,
    output logic                       rsp_lsi
);

    localparam int              IDX_W = $clog2(SRC_COUNT);
    localparam logic [ID_W:0]   LIMIT = (ID_W+1)'(SRC_COUNT);

    logic              in_rng;
    logic [IDX_W-1:0]  idx;
    logic              want;
    logic [1:0]        sel_pq;
    logic              sel_mask;
    logic              sel_lsi;

    // Select the addressed source or the fixed out-of-range view.
    always_comb begin
        in_rng   = ({1'b0, sw_id} < LIMIT);
        idx      = sw_id[IDX_W-1:0];
        want     = sw_vld && (sw_op == OP_LOAD || sw_op == OP_SWAP);
        sel_pq   = in_rng ? v_pq[idx]   : PQ_OFF;
        sel_mask = in_rng ? v_mask[idx] : 1'b1;
        sel_lsi  = in_rng ? v_lsi[idx]  : 1'b0;
    end

    // Register the response one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_pq   <= PQ_OFF;
            rsp_mask <= 1'b1;
            rsp_lsi  <= 1'b0;
        end else begin
            rsp_vld  <= want;
            rsp_pq   <= sel_pq;
            rsp_mask <= sel_mask;
            rsp_lsi  <= sel_lsi;
        end
    end

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_vld && sw_op == OP_LOAD) |=> rsp_vld); // R8
    AST_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_vld && sw_op == OP_CFG) |=> !rsp_vld); // R10

endmodule

// File: rtl/isrc_pq_array.sv
// Interrupt source event-state table: SRC_COUNT sources in a 2**ID_W number
// space, each with state, mask and type. Emits registered notify strobes for
// triggers and end-of-interrupt replays, and serves one software access per
// cycle. Assumes each port carries at most one source number per cycle.
module isrc_pq_array
    import isrc_pkg::*;
#(
    parameter int SRC_COUNT = 1024,
    parameter int ID_W      = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_vld,
    input  logic [ID_W-1:0] trig_id,
    input  logic            eoi_vld,
    input  logic [ID_W-1:0] eoi_id,
    input  logic            eoi_level,
    input  logic            sw_vld,
    input  logic [1:0]      sw_op,
    input  logic [ID_W-1:0] sw_id,
    input  logic [1:0]      sw_pq,
    input  logic            sw_mask,
    input  logic            sw_lsi,
    output logic            ntf_trig_vld,
    output logic [ID_W-1:0] ntf_trig_id,
    output logic            ntf_eoi_vld,
    output logic [ID_W-1:0] ntf_eoi_id,
    output logic            rsp_vld,
    output logic [1:0]      rsp_pq,
    output logic            rsp_mask,
    output logic            rsp_lsi
);

    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(SRC_COUNT);

    logic [SRC_COUNT-1:0]      t_hit;
    logic [SRC_COUNT-1:0]      e_hit;
    logic [SRC_COUNT-1:0]      s_hit;
    logic [SRC_COUNT-1:0]      t_ntf;
    logic [SRC_COUNT-1:0]      e_ntf;
    logic [SRC_COUNT-1:0][1:0] v_pq;
    logic [SRC_COUNT-1:0]      v_mask;
    logic [SRC_COUNT-1:0]      v_lsi;

    for (genvar g = 0; g < SRC_COUNT; g++) begin : g_src
        assign t_hit[g] = trig_vld && (trig_id == ID_W'(g));
        assign e_hit[g] = eoi_vld  && (eoi_id  == ID_W'(g));
        assign s_hit[g] = sw_vld   && (sw_id   == ID_W'(g));

        isrc_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_hit  (t_hit[g]),
            .eoi_hit   (e_hit[g]),
            .eoi_lvl   (eoi_level),
            .sw_hit    (s_hit[g]),
            .sw_op     (sw_op),
            .sw_pq     (sw_pq),
            .sw_mask   (sw_mask),
            .sw_lsi    (sw_lsi),
            .trig_ntf  (t_ntf[g]),
            .eoi_ntf   (e_ntf[g]),
            .view_pq   (v_pq[g]),
            .view_mask (v_mask[g]),
            .view_lsi  (v_lsi[g])
        );
    end

    // Register both notify channels with the source number that caused them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_trig_vld <= 1'b0;
            ntf_trig_id  <= '0;
            ntf_eoi_vld  <= 1'b0;
            ntf_eoi_id   <= '0;
        end else begin
            ntf_trig_vld <= |t_ntf;
            ntf_eoi_vld  <= |e_ntf;
            if (trig_vld) ntf_trig_id <= trig_id;
            if (eoi_vld)  ntf_eoi_id  <= eoi_id;
        end
    end

    isrc_rd_port #(
        .SRC_COUNT (SRC_COUNT),
        .ID_W      (ID_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_vld   (sw_vld),
        .sw_op    (sw_op),
        .sw_id    (sw_id),
        .v_pq     (v_pq),
        .v_mask   (v_mask),
        .v_lsi    (v_lsi),
        .rsp_vld  (rsp_vld),
        .rsp_pq   (rsp_pq),
        .rsp_mask (rsp_mask),
        .rsp_lsi  (rsp_lsi)
    );

    AST_TRIG_NTF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_trig_vld |-> ($past(trig_vld) && ntf_trig_id == $past(trig_id))); // R2
    AST_EOI_NTF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_eoi_vld |-> ($past(eoi_vld) && ntf_eoi_id == $past(eoi_id))); // R6
    AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_vld && ({1'b0, trig_id} >= LIMIT)) |=> !ntf_trig_vld); // R12

endmodule

// File: tb/isrc_pq_array_tb_top.sv
`timescale 1ns/1ps
module isrc_pq_array_tb_top;

    localparam int N  = 64;
    localparam int IW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_vld = 0, eoi_vld = 0, eoi_level = 0, sw_vld = 0;
    logic [IW-1:0] trig_id = '0, eoi_id = '0, sw_id = '0;
    logic [1:0]    sw_op = 2'b11, sw_pq = '0;
    logic          sw_mask = 0, sw_lsi = 0;
    logic          ntf_trig_vld, ntf_eoi_vld, rsp_vld, rsp_mask, rsp_lsi;
    logic [IW-1:0] ntf_trig_id, ntf_eoi_id;
    logic [1:0]    rsp_pq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [1:0] m_pq   [N];
    logic       m_mask [N];
    logic       m_lsi  [N];

    always #2.5 clk = ~clk;

    isrc_pq_array #(.SRC_COUNT(N), .ID_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .trig_vld(trig_vld), .trig_id(trig_id),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .eoi_level(eoi_level),
        .sw_vld(sw_vld), .sw_op(sw_op), .sw_id(sw_id),
        .sw_pq(sw_pq), .sw_mask(sw_mask), .sw_lsi(sw_lsi),
        .ntf_trig_vld(ntf_trig_vld), .ntf_trig_id(ntf_trig_id),
        .ntf_eoi_vld(ntf_eoi_vld), .ntf_eoi_id(ntf_eoi_id),
        .rsp_vld(rsp_vld), .rsp_pq(rsp_pq), .rsp_mask(rsp_mask), .rsp_lsi(rsp_lsi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model of trigger: returns expected notify and updates the model.
    function automatic bit mdl_trig(input int id);
        bit n = 0;
        if (id < N) begin
            n = (m_pq[id] == 2'b00) && !m_mask[id];
            if (m_pq[id] == 2'b00)      m_pq[id] = 2'b10;
            else if (m_pq[id] == 2'b10) m_pq[id] = 2'b11;
        end
        return n;
    endfunction

    // Model of end-of-interrupt: returns expected replay and updates the model.
    function automatic bit mdl_eoi(input int id, input bit lvl);
        bit n = 0;
        bit hold;
        if (id < N) begin
            hold = m_lsi[id] && lvl;
            n = ((m_pq[id] == 2'b11) || (m_pq[id] == 2'b10 && hold)) && !m_mask[id];
            if (m_pq[id] == 2'b10)      m_pq[id] = hold ? 2'b10 : 2'b00;
            else if (m_pq[id] == 2'b11) m_pq[id] = 2'b10;
        end
        return n;
    endfunction

    // One clock of stimulus, checked against the model one edge later.
    task automatic step(input bit tv, input int tid, input bit ev, input int eid, input bit el,
                        input bit sv, input logic [1:0] op, input int sid,
                        input logic [1:0] npq, input bit nm, input bit nl, input string req);
        bit         x_nt, x_ne, x_rv;
        logic [3:0] x_rd;
        @(negedge clk);
        trig_vld = tv; trig_id = IW'(tid);
        eoi_vld = ev;  eoi_id = IW'(eid); eoi_level = el;
        sw_vld = sv;   sw_op = op; sw_id = IW'(sid);
        sw_pq = npq;   sw_mask = nm; sw_lsi = nl;
        x_nt = tv ? mdl_trig(tid) : 1'b0;
        x_ne = ev ? mdl_eoi(eid, el) : 1'b0;
        x_rv = sv && (op == 2'b00 || op == 2'b01);
        x_rd = (sid < N) ? {m_pq[sid], m_mask[sid], m_lsi[sid]} : 4'b0110;
        if (sv && sid < N) begin
            if (op == 2'b01) m_pq[sid] = npq;
            if (op == 2'b10) begin m_mask[sid] = nm; m_lsi[sid] = nl; end
        end
        @(posedge clk); #1;
        chk(ntf_trig_vld == x_nt, (req == "") ? "R2" : req, "trig notify", 16'(ntf_trig_vld), 16'(x_nt));
        if (x_nt) chk(ntf_trig_id == IW'(tid), "R2", "trig id", 16'(ntf_trig_id), 16'(tid));
        chk(ntf_eoi_vld == x_ne, (req == "") ? "R6" : req, "eoi notify", 16'(ntf_eoi_vld), 16'(x_ne));
        if (x_ne) chk(ntf_eoi_id == IW'(eid), "R6", "eoi id", 16'(ntf_eoi_id), 16'(eid));
        chk(rsp_vld == x_rv, (req == "") ? "R8" : req, "rsp valid", 16'(rsp_vld), 16'(x_rv));
        if (x_rv) chk({rsp_pq, rsp_mask, rsp_lsi} == x_rd, (req == "") ? "R9" : req, "rsp data",
                      16'({rsp_pq, rsp_mask, rsp_lsi}), 16'(x_rd));
        trig_vld = 0; eoi_vld = 0; sw_vld = 0;
    endtask

    task automatic rd(input int id, input string req);
        step(0, 0, 0, 0, 0, 1, 2'b00, id, 2'b00, 0, 0, req);
    endtask
    task automatic sw(input int id, input logic [1:0] npq, input string req);
        step(0, 0, 0, 0, 0, 1, 2'b01, id, npq, 0, 0, req);
    endtask
    task automatic cfg(input int id, input bit nm, input bit nl, input string req);
        step(0, 0, 0, 0, 0, 1, 2'b10, id, 2'b00, nm, nl, req);
    endtask
    task automatic trg(input int id, input string req);
        step(1, id, 0, 0, 0, 0, 2'b11, 0, 2'b00, 0, 0, req);
    endtask
    task automatic eoi(input int id, input bit lvl, input string req);
        step(0, 0, 1, id, lvl, 0, 2'b11, 0, 2'b00, 0, 0, req);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_pq[i] = 2'b01; m_mask[i] = 1; m_lsi[i] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!ntf_trig_vld && !ntf_eoi_vld && !rsp_vld, "R1", "outputs idle", 16'({ntf_trig_vld, ntf_eoi_vld, rsp_vld}), 16'h0);
        rd(0, "R1"); rd(5, "R1"); rd(N-1, "R1");
        // R9, R10: configure then swap from off to ready
        cfg(3, 0, 0, "R10");
        sw(3, 2'b00, "R9");
        // R2, R3: trigger path
        trg(3, "R2"); trg(3, "R3"); trg(3, "R3"); rd(3, "R3");
        // R6: replay from queued, then back to ready
        eoi(3, 0, "R6"); rd(3, "R6"); eoi(3, 0, "R6"); rd(3, "R6"); eoi(3, 0, "R6");
        // R4: off source ignores triggers
        cfg(4, 0, 0, "R10"); trg(4, "R4"); rd(4, "R4"); eoi(4, 0, "R4");
        // R5: masked source moves but never notifies
        sw(5, 2'b00, "R9"); trg(5, "R5"); trg(5, "R5"); eoi(5, 0, "R5"); rd(5, "R5");
        // R7: level-sensitive source refires while level high
        cfg(6, 0, 1, "R10"); sw(6, 2'b00, "R9"); trg(6, "R7");
        eoi(6, 1, "R7"); rd(6, "R7"); eoi(6, 0, "R7"); rd(6, "R7");
        // R6: level input has no effect on a type-0 source
        cfg(8, 0, 0, "R10"); sw(8, 2'b00, "R9"); trg(8, "R6"); eoi(8, 1, "R6"); rd(8, "R6");
        // R11: trigger, eoi and read on one source in one cycle
        cfg(7, 0, 0, "R10"); sw(7, 2'b00, "R9");
        step(1, 7, 1, 7, 0, 1, 2'b00, 7, 2'b00, 0, 0, "R11");
        step(1, 7, 1, 7, 0, 1, 2'b01, 7, 2'b01, 0, 0, "R11");
        rd(7, "R11");
        // R12: out-of-range numbers
        step(1, 100, 1, 100, 1, 1, 2'b01, 100, 2'b00, 0, 0, "R12");
        rd(100, "R12"); rd(8191, "R12"); trg(8191, "R12");
        // Random phase over a window straddling the table end
        for (int k = 0; k < 3000; k++) begin
            step($urandom_range(0, 1), $urandom_range(0, N+7),
                 $urandom_range(0, 2) == 0, $urandom_range(0, N+7), $urandom_range(0, 1),
                 $urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom_range(0, N+7),
                 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, $urandom_range(0, 1), "");
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule